// File: doc/BRIEF.md
# Conversion Sync and Settling Tracker

This block tracks the conversion timing of a delta-sigma converter and decides, for every synchronisation event, whether the decimation filter must restart. It runs on the converter master clock and keeps a free-running phase counter that marks the end of each conversion period with a one-cycle data-ready strobe. A rising edge on the sync input, or a channel-change request, can abort the conversion in progress. The block then re-anchors the period grid to that edge, emits a one-cycle restart pulse and holds the result-valid qualifier low until the selected filter path has settled.

Two sync behaviours are supported. In pulse mode, every sync edge restarts the filter. In continuous mode, an edge that lands on the conversion-period grid is taken as confirming the current timing and is ignored. Only an edge that lands off the grid restarts the filter. The tolerance of half a master clock reduces, in whole clocks, to an exact match with phase zero. The settling length depends on the filter path selected at the moment of the restart. The longer FIR path needs 63 periods and the sinc path needs 5. Data-ready keeps pulsing throughout settling, so downstream logic sees a steady cadence and only the qualifier changes.

Top module: `sync_settle_tracker`

## Requirements
- R1: While rst_ni is low, drdy_o, valid_o and restart_o are 0. Release from reset acts as a restart with the longest settling length (63): the first 62 data-ready strobes after reset carry valid_o=0 and the 63rd carries valid_o=1.
- R2: With period_i = P (P >= 2) and no restart, drdy_o is high for exactly one cycle every P cycles. After a sync edge sampled at clock edge E, whether or not it restarts, the next drdy_o is visible P-1 clock edges after E.
- R3: With cont_mode_i=0 (pulse mode), every rising edge of sync_i restarts the filter, whatever its alignment. Holding sync_i high produces only one restart.
- R4: With cont_mode_i=1, a rising edge of sync_i sampled in a cycle where drdy_o is high (phase zero of the period grid) causes no restart: restart_o stays 0 and valid_o stays 1 on the next strobe.
- R5: With cont_mode_i=1, a rising edge of sync_i sampled in any other cycle restarts the filter and re-anchors the period grid to that edge.
- R6: Each restart event produces exactly one cycle of restart_o=1, visible in the cycle after the cycle in which the event was sampled.
- R7: A restart with sinc_sel_i=0 (FIR path) yields 62 strobes with valid_o=0, then valid_o=1 on the 63rd strobe.
- R8: A restart with sinc_sel_i=1 (sinc path) yields 4 strobes with valid_o=0, then valid_o=1 on the 5th strobe.
- R9: A one-cycle chan_chg_i=1 restarts the filter in either sync mode, with the same restart pulse and settling as a sync restart.
- R10: A restart that arrives during settling reloads the full settling length, counted from the new restart.
- R11: valid_o is high only in cycles where drdy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Converter master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Synchronisation input; rising edge is the event |
| cont_mode_i | input | 1 | 0 = pulse sync mode, 1 = continuous sync mode |
| sinc_sel_i | input | 1 | 0 = FIR filter path, 1 = sinc filter path; sampled at restart |
| chan_chg_i | input | 1 | Channel-change request, treated as a restart |
| period_i | input | PERIOD_W | Conversion period length in master clocks (>= 2) |
| drdy_o | output | 1 | One-cycle strobe at each period boundary |
| valid_o | output | 1 | Result qualifier, high with drdy_o once settled |
| restart_o | output | 1 | One-cycle pulse for each filter restart |

## Verification
A phase counter that drifts or re-anchors to the wrong cycle shows up at once. The gap to the next strobe is wrong, and aligned sync edges in continuous mode begin to restart the filter, so restart_o rises within a cycle of the first such edge. A wrong settling counter cannot be seen until the end of settling. It appears as valid_o rising on the wrong strobe, up to 63 periods after the restart. A missed reload is exposed only when a second restart lands inside that window. The bench therefore counts invalid strobes after every restart, and it checks the strobe cadence on each period.

// File: rtl/sst_pkg.sv
package sst_pkg;
  typedef enum logic {SYNC_PULSE = 1'b0, SYNC_CONT = 1'b1} sync_mode_e;
  typedef enum logic {FILT_FIR = 1'b0, FILT_SINC = 1'b1} filt_sel_e;

  localparam int unsigned FIR_SETTLE_DEF  = 63;
  localparam int unsigned SINC_SETTLE_DEF = 5;
endpackage

// File: rtl/sst_edge_det.sv
module sst_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;

  AST_RISE_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R3
endmodule

// File: rtl/sst_phase_ctr.sv
module sst_phase_ctr #(
  parameter int unsigned PERIOD_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic                restart_i,
  output logic [PERIOD_W-1:0] phase_o,
  output logic                zero_o,
  output logic                tick_o
);
  localparam logic [PERIOD_W-1:0] ONE = PERIOD_W'(1);

  logic [PERIOD_W-1:0] phase_q;

  // >= keeps the counter bounded if period_i shrinks mid-period
  assign tick_o  = (phase_q >= (period_i - ONE));
  assign zero_o  = (phase_q == '0);
  assign phase_o = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        phase_q <= '0;
    else if (restart_i) phase_q <= ONE;  // edge cycle is phase zero
    else if (tick_o)    phase_q <= '0;
    else                phase_q <= phase_q + ONE;
  end

  AST_PHASE_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_i && !tick_o) |=> (phase_q == $past(phase_q) + ONE)); // R2
endmodule

// File: rtl/sst_restart_ctl.sv
module sst_restart_ctl (
  input  logic rise_i,
  input  logic chan_chg_i,
  input  logic cont_mode_i,
  input  logic phase_zero_i,
  output logic restart_o
);
  import sst_pkg::*;

  sync_mode_e mode;
  logic       sync_restart;

  assign mode = sync_mode_e'(cont_mode_i);

  always_comb begin
    sync_restart = 1'b0;
    if (rise_i) begin
      unique case (mode)
        SYNC_PULSE: sync_restart = 1'b1;
        SYNC_CONT:  sync_restart = ~phase_zero_i;
        default:    sync_restart = 1'b1;
      endcase
    end
  end

  assign restart_o = sync_restart | chan_chg_i;
endmodule

// File: rtl/sst_settle_ctr.sv
module sst_settle_ctr #(
  parameter int unsigned FIR_SETTLE  = sst_pkg::FIR_SETTLE_DEF,
  parameter int unsigned SINC_SETTLE = sst_pkg::SINC_SETTLE_DEF,
  localparam int unsigned MAX_SETTLE = (FIR_SETTLE > SINC_SETTLE) ? FIR_SETTLE : SINC_SETTLE,
  localparam int unsigned SETTLE_W   = $clog2(MAX_SETTLE + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                restart_i,
  input  logic                sinc_sel_i,
  input  logic                tick_i,
  output logic                ok_o,
  output logic [SETTLE_W-1:0] left_o
);
  import sst_pkg::*;

  localparam logic [SETTLE_W-1:0] LEN_FIR  = SETTLE_W'(FIR_SETTLE);
  localparam logic [SETTLE_W-1:0] LEN_SINC = SETTLE_W'(SINC_SETTLE);
  localparam logic [SETTLE_W-1:0] LEN_MAX  = SETTLE_W'(MAX_SETTLE);

  logic [SETTLE_W-1:0] left_q;
  logic [SETTLE_W-1:0] load_len;

  assign load_len = (filt_sel_e'(sinc_sel_i) == FILT_SINC) ? LEN_SINC : LEN_FIR;
  // the strobe that takes the count from 1 to 0 is the first valid one
  assign ok_o   = (left_q <= SETTLE_W'(1));
  assign left_o = left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       left_q <= LEN_MAX;
    else if (restart_i)                left_q <= load_len;
    else if (tick_i && left_q != '0)   left_q <= left_q - SETTLE_W'(1);
  end

  AST_SETTLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_i && !tick_i) |=> $stable(left_q)); // R7
  AST_SETTLE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    left_q <= LEN_MAX); // R10
endmodule

// File: rtl/sync_settle_tracker.sv
module sync_settle_tracker #(
  parameter int unsigned PERIOD_W    = 16,
  parameter int unsigned FIR_SETTLE  = sst_pkg::FIR_SETTLE_DEF,
  parameter int unsigned SINC_SETTLE = sst_pkg::SINC_SETTLE_DEF,
  localparam int unsigned MAX_SETTLE = (FIR_SETTLE > SINC_SETTLE) ? FIR_SETTLE : SINC_SETTLE,
  localparam int unsigned SETTLE_W   = $clog2(MAX_SETTLE + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sync_i,
  input  logic                cont_mode_i,
  input  logic                sinc_sel_i,
  input  logic                chan_chg_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                drdy_o,
  output logic                valid_o,
  output logic                restart_o
);
  logic                sync_rise;
  logic                restart_req;
  logic [PERIOD_W-1:0] phase;
  logic                phase_zero;
  logic                tick;
  logic                settled;
  logic [SETTLE_W-1:0] settle_left;

  sst_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (sync_i),
    .rise_o (sync_rise)
  );

  sst_phase_ctr #(.PERIOD_W(PERIOD_W)) u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .period_i  (period_i),
    .restart_i (restart_req),
    .phase_o   (phase),
    .zero_o    (phase_zero),
    .tick_o    (tick)
  );

  sst_restart_ctl u_rctl (
    .rise_i       (sync_rise),
    .chan_chg_i   (chan_chg_i),
    .cont_mode_i  (cont_mode_i),
    .phase_zero_i (phase_zero),
    .restart_o    (restart_req)
  );

  sst_settle_ctr #(.FIR_SETTLE(FIR_SETTLE), .SINC_SETTLE(SINC_SETTLE)) u_settle (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .restart_i  (restart_req),
    .sinc_sel_i (sinc_sel_i),
    .tick_i     (tick),
    .ok_o       (settled),
    .left_o     (settle_left)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drdy_o    <= 1'b0;
      valid_o   <= 1'b0;
      restart_o <= 1'b0;
    end else begin
      drdy_o    <= tick & ~restart_req;
      valid_o   <= tick & settled & ~restart_req;
      restart_o <= restart_req;
    end
  end

  AST_DRDY_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drdy_o && period_i >= PERIOD_W'(2)) |=> !drdy_o); // R2
  AST_VALID_QUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> drdy_o); // R11
  AST_RESTART_ANCHOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |-> (phase == PERIOD_W'(1))); // R5
  AST_RESTART_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |-> (settle_left == SETTLE_W'(FIR_SETTLE) || settle_left == SETTLE_W'(SINC_SETTLE))); // R10
  AST_PULSE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cont_mode_i && sync_rise) |=> restart_o); // R3
  AST_ALIGNED_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cont_mode_i && sync_rise && drdy_o && !chan_chg_i) |=> !restart_o); // R4
  AST_CHAN_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_chg_i |=> restart_o); // R9
endmodule

// File: tb/sync_settle_tracker_tb.sv
module sync_settle_tracker_tb_top;
  localparam int P  = 8;
  localparam int PW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_i = 1'b0, cont_mode = 1'b0, sinc_sel = 1'b0, chan_chg = 1'b0;
  logic [PW-1:0] period = PW'(P);
  logic drdy, valid, restart;

  int errors = 0;
  int checks = 0;
  int bad_qual = 0;

  always #10 clk = ~clk;

  sync_settle_tracker #(.PERIOD_W(PW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sync_i(sync_i), .cont_mode_i(cont_mode),
    .sinc_sel_i(sinc_sel), .chan_chg_i(chan_chg), .period_i(period),
    .drdy_o(drdy), .valid_o(valid), .restart_o(restart)
  );

  typedef struct packed {
    logic      cont;
    logic      sinc;
    logic [3:0] off;
    logic      exp_rst;
    logic [6:0] exp_inv;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 1'b1, 4'd0, 1'b1, 7'd4},   // R3 aligned pulse still restarts
    '{1'b0, 1'b0, 4'd3, 1'b1, 7'd62},  // R3 R7
    '{1'b1, 1'b1, 4'd0, 1'b0, 7'd0},   // R4
    '{1'b1, 1'b1, 4'd1, 1'b1, 7'd4},   // R5 R8
    '{1'b1, 1'b0, 4'd7, 1'b1, 7'd62},  // R5 R7
    '{1'b1, 1'b0, 4'd0, 1'b0, 7'd0},   // R4
    '{1'b1, 1'b1, 4'd2, 1'b1, 7'd4},   // R5 R8
    '{1'b0, 1'b1, 4'd5, 1'b1, 7'd4}    // R3 R8
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && valid && !drdy) bad_qual++;

  // returns negedges waited until drdy is seen
  task automatic wait_drdy(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!drdy && n < 4 * P);
  endtask

  // from a strobe, count invalid strobes until the first valid one
  task automatic count_invalid(input string req, output int inv);
    int gap;
    inv = 0;
    while (!valid && inv < 80) begin
      inv++;
      wait_drdy(gap);
      chk(gap == P, "R2 cadence", gap, P);
    end
  endtask

  task automatic fire_sync(input int off, input string req, input bit exp_rst);
    int n;
    repeat (off) @(negedge clk);
    sync_i = 1'b1;
    @(negedge clk);
    sync_i = 1'b0;
    chk(restart == exp_rst, req, restart, exp_rst);
    wait_drdy(n);
    chk(n == P - 1, "R2 first strobe after sync", n, P - 1);
  endtask

  task automatic fire_chan(input bit sinc);
    int n;
    sinc_sel = sinc;
    chan_chg = 1'b1;
    @(negedge clk);
    chan_chg = 1'b0;
    chk(restart == 1'b1, "R9 chan restart", restart, 1);
    @(negedge clk);
    chk(restart == 1'b0, "R6 restart one cycle", restart, 0);
    wait_drdy(n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n, inv, rcount;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(drdy == 0 && valid == 0 && restart == 0, "R1 reset outputs", {drdy, valid, restart}, 0);
    rst_n = 1'b1;
    wait_drdy(n);
    chk(n == P, "R2 first strobe after reset", n, P);
    count_invalid("R1", inv);
    chk(inv == 62, "R1 reset settling", inv, 62);

    // table-driven sync cases
    foreach (VECS[i]) begin
      cont_mode = VECS[i].cont;
      sinc_sel  = VECS[i].sinc;
      wait_drdy(n);
      fire_sync(int'(VECS[i].off), VECS[i].exp_rst ? "R5/R3 restart" : "R4 no restart", VECS[i].exp_rst);
      if (VECS[i].exp_rst) begin
        chk(valid == 0, "R7/R8 first strobe invalid", valid, 0);
        count_invalid("R7/R8", inv);
        chk(inv == int'(VECS[i].exp_inv), VECS[i].sinc ? "R8 sinc settling" : "R7 FIR settling", inv, int'(VECS[i].exp_inv));
      end else begin
        chk(valid == 1, "R4 stays valid", valid, 1);
      end
    end

    // R9 channel change, R10 reload during settling
    cont_mode = 1'b1;
    wait_drdy(n);
    repeat (2) @(negedge clk);
    fire_chan(1'b1);
    chk(valid == 0, "R9 invalid after chan", valid, 0);
    wait_drdy(n);
    fire_chan(1'b1);
    count_invalid("R10", inv);
    chk(inv == 4, "R10 reload settling", inv, 4);

    // R3 held sync gives one restart, R6 single pulse
    cont_mode = 1'b0;
    sinc_sel  = 1'b1;
    wait_drdy(n);
    @(negedge clk);
    sync_i = 1'b1;
    rcount = 0;
    for (int k = 0; k < 3 * P; k++) begin
      @(negedge clk);
      if (restart) rcount++;
    end
    sync_i = 1'b0;
    chk(rcount == 1, "R3 R6 held sync one restart", rcount, 1);
    wait_drdy(n);
    count_invalid("R8", inv);
    chk(valid == 1, "R8 settled after held sync", valid, 1);

    chk(bad_qual == 0, "R11 valid only with drdy", bad_qual, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule